// File: doc/BRIEF.md
# I2C Register Target with Pointer Auto-Increment

This block is an I2C target with a 7-bit address. It gives an external bus master access to a small file of nine byte-wide configuration registers. SCL and SDA are sampled by a faster system clock. Each line passes through a two-flop synchronizer and a filter that rejects single-sample pulses before the edges are decoded.

The block recognises START, repeated START and STOP. It compares the address byte with its own device address and loads a register pointer from the byte that follows. A write continues into a burst of data bytes. A read is a register-pointer write, then a repeated START with the read bit set, then data bytes that the block shifts out. SDA is only ever pulled low, through an output-enable. The register contents go to neighbouring logic as one flat parallel bus.

The protocol engine is one state machine with these states:
- ST_IDLE: waiting for START.
- ST_ADDR: shifting in the device address.
- ST_ADDR_ACK: acknowledging the address.
- ST_REG: shifting in the pointer byte.
- ST_REG_ACK: answering the pointer byte.
- ST_WR: shifting in a data byte.
- ST_WR_ACK: acknowledging a data byte.
- ST_RD: shifting out a data byte.
- ST_RD_ACK: sampling the master's answer.

Transitions:
- START from any state goes to ST_ADDR. STOP from any state goes to ST_IDLE.
- At the eighth SCL fall:
  - ST_ADDR goes to ST_ADDR_ACK on a match, otherwise to ST_IDLE.
  - ST_REG goes to ST_REG_ACK for a valid pointer, otherwise to ST_IDLE.
  - ST_WR goes to ST_WR_ACK.
  - ST_RD goes to ST_RD_ACK.
- At the ninth SCL fall:
  - ST_ADDR_ACK goes to ST_RD or ST_REG, chosen by the R/W bit.
  - ST_REG_ACK and ST_WR_ACK go to ST_WR.
  - ST_RD_ACK goes back to ST_RD on a master ACK, or to ST_IDLE on a NAK.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset, regs_o carries register n in bits 8n+7..8n. The reset values are: 0x00=0x10, 0x01=0x87, 0x02=0x50, 0x03=0xE9, 0x04=0x00, 0x05=0x7B, 0x06=0x00, 0x07=0x00, 0x08=0x00.
- R2: The block acknowledges only an address byte whose upper seven bits equal DEV_ADDR. The default is 0x35, giving 0x6A for write and 0x6B for read; 0x15 is the alternative setting. Any other address gets no ACK, and SDA is never driven while the block is idle.
- R3: A pointer byte of 0x00 to 0x08 is acknowledged and loaded into the pointer. A pointer byte of 0x09 or higher is answered with NAK, the transfer is dropped and the pointer keeps its previous value.
- R4: Each data byte that follows an accepted pointer byte is acknowledged and stored in the register the pointer selects. The new value is visible on regs_o.
- R5: After each data byte written or read, the pointer advances by one. A pointer at 0x00 stays at 0x00, and a pointer at 0x08 stays at 0x08.
- R6: An address byte with the R/W bit (bit 0) set makes the block shift out the register at the pointer, MSB first. It keeps sending bytes while the master ACKs and releases SDA after the master's NAK.
- R7: Writes to registers 0x00, 0x06 and 0x07 are acknowledged but leave the stored value unchanged.
- R8: A START or STOP in the middle of a byte abandons that byte with no register write. A START returns the block to address matching.
- R9: The block changes its SDA drive only while SCL is low, and holds an ACK or data bit through the whole SCL high period.
- R10: A pulse one system clock wide on SCL is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the I2C clock line |
| sda_i | input | 1 | Sensed level of the I2C data line |
| sda_oe | output | 1 | When 1, pulls the data line low |
| regs_o | output | 72 | All nine registers, register n in bits 8n+7..8n |

## Verification
A wrong state or bit count shows up as a missing or misplaced ACK on the line. This appears within the same byte, one SCL period after the fault. A corrupted pointer or register does not show up until a later read returns the wrong byte, or until regs_o differs from the value the master wrote. That is one transaction later, so every burst is read back. Filter or edge-decode faults show up as phantom bits. These are caught by bursts that carry SCL glitches, followed by a full comparison of the register bus.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

    localparam int NREG = 9;
    localparam int PW   = $clog2(NREG);

    typedef logic [PW-1:0] ptr_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } tgt_state_e;

    function automatic logic [7:0] reset_value(input int idx);
        case (idx)
            0:       return 8'h10;
            1:       return 8'h87;
            2:       return 8'h50;
            3:       return 8'hE9;
            5:       return 8'h7B;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic writable(input int idx);
        return !(idx == 0 || idx == 6 || idx == 7);
    endfunction

    // Pointer 0 holds still, the last register saturates.
    function automatic ptr_t ptr_step(input ptr_t p);
        if (p == '0)               return p;
        if (p == ptr_t'(NREG - 1)) return p;
        return p + ptr_t'(1);
    endfunction

endpackage

// File: rtl/i2c_pin_filter.sv
module i2c_pin_filter #(
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [2:0] sh;
    logic       lvl;
    logic       lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh    <= {3{IDLE_LVL}};
            lvl   <= IDLE_LVL;
            lvl_q <= IDLE_LVL;
        end else begin
            sh    <= {sh[1:0], pin_i};
            lvl_q <= lvl;
            if (sh[1] == sh[2]) lvl <= sh[1];
        end
    end

    assign level_o = lvl;
    assign rise_o  = lvl & ~lvl_q;
    assign fall_o  = ~lvl & lvl_q;

    // R10
    glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl != $past(lvl)) |-> (lvl == $past(sh[2])));

endmodule

// File: rtl/i2c_rf_bank.sv
module i2c_rf_bank
    import i2c_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  ptr_t              wr_addr,
    input  logic [7:0]        wr_data,
    input  ptr_t              rd_ptr,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] regs_o
);
    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            if (writable(g)) begin : g_rw
                logic [7:0] val;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)
                        val <= reset_value(g);
                    else if (wr_en && wr_addr == ptr_t'(g))
                        val <= wr_data;
                end
                assign regs_o[g*8 +: 8] = val;

                // R4
                wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (wr_en && wr_addr == ptr_t'(g)) |=> (regs_o[g*8 +: 8] == $past(wr_data)));
            end else begin : g_ro
                assign regs_o[g*8 +: 8] = reset_value(g);
            end
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_ptr == ptr_t'(i)) rd_data = regs_o[i*8 +: 8];
        end
    end

endmodule

// File: rtl/i2c_rf_fsm.sv
module i2c_rf_fsm
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h35
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_lvl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_lvl,
    input  logic       start_ev,
    input  logic       stop_ev,
    input  logic [7:0] rd_data,
    output ptr_t       ptr_o,
    output logic       wr_en,
    output ptr_t       wr_addr,
    output logic [7:0] wr_data,
    output logic       sda_oe
);
    tgt_state_e state, nxt;
    logic [3:0] cnt;
    logic [7:0] rx;
    logic [7:0] tx;
    ptr_t       ptr;
    logic       m_nack;
    logic       byte_end;
    logic       addr_hit;
    logic       reg_ok;

    assign byte_end = scl_fall && (cnt == 4'd8);
    assign addr_hit = (rx[7:1] == DEV_ADDR);
    assign reg_ok   = (rx < 8'(NREG));
    assign ptr_o    = ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (start_ev)     nxt = ST_ADDR;
        else if (stop_ev) nxt = ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (byte_end) nxt = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) nxt = rx[0] ? ST_RD : ST_REG;
                ST_REG:      if (byte_end) nxt = reg_ok ? ST_REG_ACK : ST_IDLE;
                ST_REG_ACK:  if (scl_fall) nxt = ST_WR;
                ST_WR:       if (byte_end) nxt = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) nxt = ST_WR;
                ST_RD:       if (byte_end) nxt = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) nxt = m_nack ? ST_IDLE : ST_RD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            rx      <= '0;
            tx      <= '0;
            ptr     <= '0;
            m_nack  <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            sda_oe  <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_ev || stop_ev) begin
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_REG, ST_WR: begin
                        if (scl_rise) begin
                            rx  <= {rx[6:0], sda_lvl};
                            cnt <= cnt + 4'd1;
                        end else if (byte_end) begin
                            cnt <= '0;
                            if (state == ST_ADDR) sda_oe <= addr_hit;
                            if (state == ST_REG) begin
                                sda_oe <= reg_ok;
                                if (reg_ok) ptr <= rx[PW-1:0];
                            end
                            if (state == ST_WR) begin
                                sda_oe  <= 1'b1;
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= rx;
                                ptr     <= ptr_step(ptr);
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt    <= '0;
                            sda_oe <= 1'b0;
                            if (rx[0]) begin
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[7];
                            end
                        end
                    end
                    ST_REG_ACK, ST_WR_ACK: begin
                        if (scl_fall) sda_oe <= 1'b0;
                    end
                    ST_RD: begin
                        if (scl_rise) cnt <= cnt + 4'd1;
                        else if (byte_end) begin
                            cnt    <= '0;
                            sda_oe <= 1'b0;
                            ptr    <= ptr_step(ptr);
                        end else if (scl_fall) begin
                            tx     <= {tx[6:0], 1'b0};
                            sda_oe <= ~tx[6];
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) m_nack <= sda_lvl;
                        else if (scl_fall && !m_nack) begin
                            tx     <= rd_data;
                            sda_oe <= ~rd_data[7];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R9
    oe_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_lvl);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R5
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr < ptr_t'(NREG));

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [NREG*8-1:0] regs_o
);
    localparam int SCL_IDX = 0;
    localparam int SDA_IDX = 1;

    logic [1:0] pin_raw, pin_lvl, pin_rise, pin_fall;
    logic       start_ev, stop_ev;
    logic       wr_en;
    ptr_t       wr_addr, ptr;
    logic [7:0] wr_data, rd_data;

    assign pin_raw = {sda_i, scl_i};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_pin
            i2c_pin_filter #(.IDLE_LVL(1'b1)) u_flt (
                .clk     (clk),
                .rst_n   (rst_n),
                .pin_i   (pin_raw[g]),
                .level_o (pin_lvl[g]),
                .rise_o  (pin_rise[g]),
                .fall_o  (pin_fall[g])
            );
        end
    endgenerate

    assign start_ev = pin_lvl[SCL_IDX] & pin_fall[SDA_IDX];
    assign stop_ev  = pin_lvl[SCL_IDX] & pin_rise[SDA_IDX];

    i2c_rf_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_lvl  (pin_lvl[SCL_IDX]),
        .scl_rise (pin_rise[SCL_IDX]),
        .scl_fall (pin_fall[SCL_IDX]),
        .sda_lvl  (pin_lvl[SDA_IDX]),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .rd_data  (rd_data),
        .ptr_o    (ptr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sda_oe   (sda_oe)
    );

    i2c_rf_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_ptr  (ptr),
        .rd_data (rd_data),
        .regs_o  (regs_o)
    );

endmodule

// File: tb/i2c_reg_target_bench.sv
`timescale 1ns/1ps
module i2c_reg_target_bench;
    localparam int Q     = 8;
    localparam int NR    = 9;
    localparam logic [7:0] WADR = 8'h6A;
    localparam logic [7:0] RADR = 8'h6B;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [NR*8-1:0] regs_o;

    int checks = 0;
    int errors = 0;
    bit glitch_en = 1'b0;

    logic [7:0] exp_r [NR];
    int         eptr = 0;

    always #4 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    i2c_reg_target u_i2c_reg_target (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (m_scl),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .regs_o (regs_o)
    );

    function automatic logic [7:0] rst_byte(input int i);
        logic [7:0] t [NR] = '{8'h10, 8'h87, 8'h50, 8'hE9, 8'h00, 8'h7B, 8'h00, 8'h00, 8'h00};
        return t[i];
    endfunction

    function automatic bit is_rw(input int i);
        return (i != 0) && (i != 6) && (i != 7);
    endfunction

    function automatic int step(input int p);
        if (p == 0 || p == NR - 1) return p;
        return p + 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;
        if (glitch_en) begin
            repeat (Q/2) @(negedge clk);
            m_scl = 1'b1; @(negedge clk); m_scl = 1'b0;
            repeat (Q/2 - 1) @(negedge clk);
        end else wq();
        m_scl = 1'b1; wq();
        m_scl = 1'b0; wq();
    endtask

    // Returns 1 when the target acknowledged; checks the ACK is held (R9).
    task automatic write_byte(input logic [7:0] b, output bit ack);
        logic a1, a2;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; wq();
        m_scl = 1'b1;
        @(negedge clk); a1 = sda_line;
        repeat (Q - 2) @(negedge clk); a2 = sda_line;
        @(negedge clk);
        m_scl = 1'b0; wq();
        ack = (a1 == 1'b0);
        if (ack) check(a2 == 1'b0, "R9 ack held through SCL high", int'(a2), 0);
    endtask

    task automatic read_byte(input bit give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            m_scl = 1'b1;
            repeat (Q/2) @(negedge clk);
            b[i] = sda_line;
            repeat (Q/2) @(negedge clk);
            m_scl = 1'b0;
        end
        m_sda = give_ack ? 1'b0 : 1'b1; wq();
        m_scl = 1'b1; wq();
        m_scl = 1'b0;
        @(negedge clk); m_sda = 1'b1;
        repeat (Q - 1) @(negedge clk);
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NR; i++)
            check(regs_o[i*8 +: 8] == exp_r[i], req, int'(regs_o[i*8 +: 8]), int'(exp_r[i]));
    endtask

    task automatic do_write(input int reg_a, input int n, input logic [7:0] d [4]);
        bit ack;
        bus_start();
        write_byte(WADR, ack); check(ack, "R2 write address ACK", int'(ack), 1);
        write_byte(8'(reg_a), ack); check(ack, "R3 valid pointer ACK", int'(ack), 1);
        eptr = reg_a;
        for (int k = 0; k < n; k++) begin
            write_byte(d[k], ack); check(ack, "R4 data byte ACK", int'(ack), 1);
            if (is_rw(eptr)) exp_r[eptr] = d[k];
            eptr = step(eptr);
        end
        bus_stop();
    endtask

    task automatic read_cur(input int n);
        bit ack;
        logic [7:0] b;
        write_byte(RADR, ack); check(ack, "R6 read address ACK", int'(ack), 1);
        for (int k = 0; k < n; k++) begin
            read_byte(k != n - 1, b);
            check(b == exp_r[eptr], "R6 R5 read data at pointer", int'(b), int'(exp_r[eptr]));
            eptr = step(eptr);
        end
        bus_stop();
    endtask

    task automatic do_read(input int reg_a, input int n);
        bit ack;
        bus_start();
        write_byte(WADR, ack); check(ack, "R2 write address ACK", int'(ack), 1);
        write_byte(8'(reg_a), ack); check(ack, "R3 valid pointer ACK", int'(ack), 1);
        eptr = reg_a;
        bus_start();
        read_cur(n);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] d [4];
        void'($urandom(32'd4242));
        for (int i = 0; i < NR; i++) exp_r[i] = rst_byte(i);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset values
        check_regs("R1 reset value");
        check(sda_oe == 1'b0, "R2 idle release", int'(sda_oe), 0);

        // R2 foreign address gets no ACK
        bus_start();
        write_byte(8'h2A, ack); check(!ack, "R2 foreign address NAK", int'(ack), 0);
        bus_stop();

        // R4 plain write burst, R6 read back
        d = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
        do_write(1, 4, d);
        check_regs("R4 burst write");
        do_read(1, 4);

        // R3 out-of-range pointer NAK, pointer kept
        do_read(3, 1);
        bus_start();
        write_byte(WADR, ack);
        write_byte(8'h09, ack); check(!ack, "R3 pointer 0x09 NAK", int'(ack), 0);
        bus_stop();
        bus_start();
        write_byte(WADR, ack);
        write_byte(8'h7F, ack); check(!ack, "R3 pointer 0x7F NAK", int'(ack), 0);
        bus_stop();
        bus_start();
        read_cur(1);

        // R7 read-only registers, R5 pointer 0 holds
        d = '{8'h55, 8'h66, 8'h77, 8'h88};
        do_write(0, 2, d);
        do_write(6, 2, d);
        check_regs("R7 read-only untouched");
        do_read(0, 3);

        // R5 saturation at last register
        d = '{8'h11, 8'h22, 8'h33, 8'h44};
        do_write(7, 3, d);
        check(regs_o[8*8 +: 8] == 8'h33, "R5 saturate last write", int'(regs_o[8*8 +: 8]), 8'h33);
        do_read(8, 3);

        // R8 START mid-byte aborts, then STOP mid-byte aborts
        bus_start();
        write_byte(WADR, ack);
        write_byte(8'h02, ack);
        eptr = 2;
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_start();
        write_byte(WADR, ack); check(ack, "R8 address after abort ACK", int'(ack), 1);
        bus_stop();
        bus_start();
        write_byte(WADR, ack);
        write_byte(8'h03, ack);
        eptr = 3;
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        bus_stop();
        check_regs("R8 aborted byte not written");
        do_read(2, 2);

        // R10 one-clock SCL glitches during transfers
        glitch_en = 1'b1;
        d = '{8'h3C, 8'hC3, 8'h5A, 8'hA5};
        do_write(2, 4, d);
        glitch_en = 1'b0;
        check_regs("R10 glitch rejected");
        do_read(2, 4);

        // Random bursts
        for (int it = 0; it < 12; it++) begin
            int ra, rn;
            ra = $urandom_range(0, NR - 1);
            rn = $urandom_range(1, 4);
            for (int k = 0; k < 4; k++) d[k] = 8'($urandom);
            do_write(ra, rn, d);
            check_regs("R4 R5 R7 random burst");
            do_read($urandom_range(0, NR - 1), $urandom_range(1, 4));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule